// File: doc/BRIEF.md
# Two-Level Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken, for use in an instruction fetch stage. It keeps a short shift register of recent branch outcomes across the whole program. That register picks one of several tables of 2-bit saturating counters, and low bits of the branch address pick one counter inside that table. As a result, each static branch has one counter for every recent-outcome pattern. This lets the predictor learn branches whose direction depends on how neighbouring branches went.

The fetch side presents an address and gets a taken/not-taken answer in the same cycle, through combinational logic. The resolve side reports a branch address and its actual outcome. On the next clock edge, the counter chosen by that address and the current history moves one step toward the outcome, and the outcome is shifted into the history. By default there are four tables of 512 counters each, for 4096 bits of counter storage.

Top module: `bpred_gcorr`

## Requirements
- R1: After reset the history register is zero and every counter holds 01 (weakly not taken), so every lookup predicts not taken until an update arrives.
- R2: The prediction is the high bit of the selected counter: states 10 and 11 give taken (lookupTaken=1), and states 00 and 01 give not taken.
- R3: A taken update adds one to the selected counter. At 11 it saturates and stays at 11.
- R4: A not-taken update subtracts one from the selected counter. At 00 it saturates and stays at 00.
- R5: From 11, a single not-taken outcome leaves that counter predicting taken. From 00, a single taken outcome leaves it predicting not taken.
- R6: Every update shifts the history left by one place, with the outcome entering bit 0 (1 for taken, 0 for not taken). The 2-bit history value h selects table h for lookups.
- R7: Address bits 10:2 index the counter inside a table. Bits 1:0 and bits above 10 have no effect, so addresses that differ only there share a counter.
- R8: An update writes into the table selected by the history as it was before that same update shifts the history.
- R9: When a lookup and an update select the same counter in the same cycle, the lookup returns the counter value from before the update.
- R10: A lookup changes no state. With no update in progress, the prediction for a fixed address does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| lookupPc | input | 32 | Address of the branch being fetched |
| lookupTaken | output | 1 | Prediction for lookupPc: 1 means taken |
| resolveValid | input | 1 | A resolved branch outcome is present this cycle |
| resolvePc | input | 32 | Address of the resolved branch |
| resolveTaken | input | 1 | Actual outcome of the resolved branch: 1 means taken |

## Verification
The checks assume that every resolve and lookup input is at a known level in every cycle after reset, and that at most one resolved branch is reported per cycle. The history assertions also assume that outcomes arrive in program order, because the shift register has no way to repair a misordered history. The stimulus changes inputs only just after a rising edge, drives every input from time zero, and reports at most one outcome per cycle. It uses a small pool of branch addresses so that counters are reused. Some addresses differ only in their offset bits or their upper bits, so that aliasing, saturation and same-cycle collisions all occur.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
  // Width of each pattern counter and its reset state (weakly not taken).
  localparam int CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_RESET = ctr_t'(1);
  localparam ctr_t CTR_MAX   = {CTR_W{1'b1}};
  localparam ctr_t CTR_MIN   = '0;

  // Strobes sent from the control to the datapath.
  typedef struct packed {
    logic wrEn;     // write nextCtr into the resolve-selected counter
    logic shiftEn;  // shift the history register
    logic shiftBit; // bit that enters the history
    ctr_t nextCtr;  // new value for the resolve-selected counter
  } strobe_t;
endpackage

// File: rtl/bpred_dp.sv
module bpred_dp
  import bpred_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int HIST_W = 2,
  parameter int IDX_W  = 9,
  parameter int IDX_LO = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   lookupPc,
  input  logic [PC_W-1:0]   resolvePc,
  input  strobe_t           strb,
  output ctr_t              lookupCtr,
  output ctr_t              resolveCtr,
  output logic [HIST_W-1:0] histQ
);
  localparam int TABLES  = 1 << HIST_W;
  localparam int ENTRIES = 1 << IDX_W;

  logic [IDX_W-1:0]  lookIdx;
  logic [IDX_W-1:0]  resIdx;
  logic [HIST_W-1:0] histNext;
  ctr_t              lookOf [TABLES];
  ctr_t              resOf  [TABLES];

  assign lookIdx = lookupPc[IDX_LO +: IDX_W];
  assign resIdx  = resolvePc[IDX_LO +: IDX_W];

  // Next history: shift the new outcome into bit 0.
  generate
    if (HIST_W == 1) begin : g_hist1
      assign histNext = strb.shiftBit;
    end else begin : g_histN
      assign histNext = {histQ[HIST_W-2:0], strb.shiftBit};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      histQ <= '0;
    end else if (strb.shiftEn) begin
      histQ <= histNext;
    end
  end

  // One counter bank per history pattern.
  generate
    for (genvar t = 0; t < TABLES; t++) begin : g_bank
      ctr_t bank [ENTRIES];
      logic bankWr;

      assign bankWr = strb.wrEn && (histQ == HIST_W'(t));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int e = 0; e < ENTRIES; e++) begin
            bank[e] <= CTR_RESET;
          end
        end else if (bankWr) begin
          bank[resIdx] <= strb.nextCtr;
        end
      end

      assign lookOf[t] = bank[lookIdx];
      assign resOf[t]  = bank[resIdx];
    end
  endgenerate

  // The current (pre-shift) history selects the bank on both sides.
  assign lookupCtr  = lookOf[histQ];
  assign resolveCtr = resOf[histQ];
endmodule

// File: rtl/bpred_ctl.sv
module bpred_ctl
  import bpred_pkg::*;
(
  input  logic    resolveValid,
  input  logic    resolveTaken,
  input  ctr_t    resolveCtr,
  output strobe_t strb
);
  ctr_t stepped;

  // Saturating step toward the outcome.
  always_comb begin
    stepped = resolveCtr;
    if (resolveTaken) begin
      if (resolveCtr != CTR_MAX) stepped = resolveCtr + ctr_t'(1);
    end else begin
      if (resolveCtr != CTR_MIN) stepped = resolveCtr - ctr_t'(1);
    end
  end

  always_comb begin
    strb.wrEn     = resolveValid;
    strb.shiftEn  = resolveValid;
    strb.shiftBit = resolveTaken;
    strb.nextCtr  = stepped;
  end
endmodule

// File: rtl/bpred_gcorr.sv
module bpred_gcorr
  import bpred_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int HIST_W = 2,
  parameter int IDX_W  = 9,
  parameter int IDX_LO = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookupPc,
  output logic            lookupTaken,
  input  logic            resolveValid,
  input  logic [PC_W-1:0] resolvePc,
  input  logic            resolveTaken
);
  strobe_t           strb;
  ctr_t              lookupCtr;
  ctr_t              resolveCtr;
  logic [HIST_W-1:0] histQ;

  bpred_ctl u_ctl (
    .resolveValid (resolveValid),
    .resolveTaken (resolveTaken),
    .resolveCtr   (resolveCtr),
    .strb         (strb)
  );

  bpred_dp #(
    .PC_W   (PC_W),
    .HIST_W (HIST_W),
    .IDX_W  (IDX_W),
    .IDX_LO (IDX_LO)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .lookupPc   (lookupPc),
    .resolvePc  (resolvePc),
    .strb       (strb),
    .lookupCtr  (lookupCtr),
    .resolveCtr (resolveCtr),
    .histQ      (histQ)
  );

  assign lookupTaken = lookupCtr[CTR_W-1];
endmodule

// File: rtl/bpred_gcorr_chk.sv
module bpred_gcorr_chk
  import bpred_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int HIST_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [PC_W-1:0]   lookupPc,
  input logic              lookupTaken,
  input logic              resolveValid,
  input logic              resolveTaken,
  input logic [HIST_W-1:0] histQ,
  input ctr_t              resolveCtr,
  input ctr_t              nextCtr
);
  // R6: the outcome enters bit 0 of the history on each update.
  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rstN)
    resolveValid |=> histQ == HIST_W'({$past(histQ), $past(resolveTaken)}));

  // R10: without an update the history holds its value.
  assert_hist_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !resolveValid |=> $stable(histQ));

  // R3: a taken update moves the counter up by one, or holds it at the top.
  assert_sat_up_R3: assert property (@(posedge clk) disable iff (!rstN)
    (resolveValid && resolveTaken) |->
      ((resolveCtr == CTR_MAX) ? (nextCtr == CTR_MAX) : (nextCtr == resolveCtr + ctr_t'(1))));

  // R4: a not-taken update moves the counter down by one, or holds it at zero.
  assert_sat_dn_R4: assert property (@(posedge clk) disable iff (!rstN)
    (resolveValid && !resolveTaken) |->
      ((resolveCtr == CTR_MIN) ? (nextCtr == CTR_MIN) : (nextCtr == resolveCtr - ctr_t'(1))));

  // R10: with no update in the previous cycle and the same address, the prediction is stable.
  assert_lookup_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!resolveValid) && $stable(lookupPc)) |-> $stable(lookupTaken));
endmodule

bind bpred_gcorr bpred_gcorr_chk #(
  .PC_W   (PC_W),
  .HIST_W (HIST_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .lookupPc     (lookupPc),
  .lookupTaken  (lookupTaken),
  .resolveValid (resolveValid),
  .resolveTaken (resolveTaken),
  .histQ        (histQ),
  .resolveCtr   (resolveCtr),
  .nextCtr      (strb.nextCtr)
);

// File: tb/sim_bpred_gcorr.sv
module sim_bpred_gcorr;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lookupPc = '0;
  logic        lookupTaken;
  logic        resolveValid = 1'b0;
  logic [31:0] resolvePc = '0;
  logic        resolveTaken = 1'b0;

  always #5 clk = ~clk;

  bpred_gcorr u0 (
    .clk          (clk),
    .rstN         (rstN),
    .lookupPc     (lookupPc),
    .lookupTaken  (lookupTaken),
    .resolveValid (resolveValid),
    .resolvePc    (resolvePc),
    .resolveTaken (resolveTaken)
  );

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t q[$];
  int    total = 0;
  int    bad = 0;
  bit    finished = 0;
  int    mdl [4][512];
  int    hist = 0;

  function automatic int ix(input logic [31:0] pc);
    return int'(pc[10:2]);
  endfunction

  task automatic mdlReset();
    for (int t = 0; t < 4; t++)
      for (int e = 0; e < 512; e++)
        mdl[t][e] = 1;
    hist = 0;
  endtask

  // Driver: apply one cycle of stimulus, queue the expected prediction, update the model.
  task automatic step(input logic [31:0] lpc, input logic rv, input logic [31:0] rpc,
                      input logic rt, input string tag);
    item_t it;
    lookupPc     = lpc;
    resolveValid = rv;
    resolvePc    = rpc;
    resolveTaken = rt;
    it.exp = (mdl[hist][ix(lpc)] >= 2);
    it.tag = tag;
    q.push_back(it);
    if (rv) begin
      int i = ix(rpc);
      if (rt && mdl[hist][i] < 3) mdl[hist][i]++;
      else if (!rt && mdl[hist][i] > 0) mdl[hist][i]--;
      hist = ((hist << 1) | int'(rt)) & 3;
    end
    @(posedge clk);
    #1;
  endtask

  // Monitor: compare in the middle of each cycle.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total++;
      if (lookupTaken !== it.exp) begin
        bad++;
        $display("FAIL %s: lookupTaken actual=%0b expected=%0b", it.tag, lookupTaken, it.exp);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [31:0] PA = 32'h0000_0040;
  localparam logic [31:0] PB = 32'h0000_0124;

  initial begin
    mdlReset();
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;

    // R1: reset state predicts not taken everywhere.
    for (int k = 0; k < 8; k++) step(32'(k * 68), 1'b0, '0, 1'b0, "R1");

    // R8: taken at PA with history 0, then two not-taken elsewhere bring history back to 0.
    step(PA, 1'b1, PA, 1'b1, "R9");
    step(PA, 1'b1, PB, 1'b0, "R6");
    step(PA, 1'b1, PB, 1'b0, "R6");
    step(PA, 1'b0, '0, 1'b0, "R8");

    // R3, R2: saturate PA upward under history 11.
    for (int k = 0; k < 6; k++) step(PA, 1'b1, PA, 1'b1, "R3");
    // R5: one not-taken from 11 in table 3, then return history to 11.
    step(PA, 1'b1, PA, 1'b0, "R5");
    step(PA, 1'b1, PB, 1'b1, "R5");
    step(PA, 1'b1, PB, 1'b1, "R5");
    step(PA, 1'b0, '0, 1'b0, "R5");
    step(PA, 1'b0, '0, 1'b0, "R2");

    // R4: saturate PB downward under history 00.
    for (int k = 0; k < 6; k++) step(PB, 1'b1, PB, 1'b0, "R4");
    // R5: a single taken from 00 keeps not-taken after history returns to 00.
    step(PB, 1'b1, PB, 1'b1, "R5");
    step(PB, 1'b1, PA, 1'b0, "R5");
    step(PB, 1'b1, PA, 1'b0, "R5");
    step(PB, 1'b0, '0, 1'b0, "R5");

    // R7: aliasing through offset bits and upper bits.
    for (int k = 0; k < 4; k++) step(PA | 32'(k), 1'b1, PA | 32'(k), 1'b1, "R7");
    step(PA | 32'h8000_0800, 1'b0, '0, 1'b0, "R7");
    step(PA | 32'h0001_0003, 1'b0, '0, 1'b0, "R7");

    // R10: idle cycles, prediction unchanged.
    for (int k = 0; k < 5; k++) step(PA, 1'b0, '0, 1'b0, "R10");

    // R9: repeated same-counter collisions.
    for (int k = 0; k < 6; k++) step(PB, 1'b1, PB, k[0], "R9");

    // R6: mixed random traffic over a small address pool.
    for (int k = 0; k < 400; k++) begin
      logic [31:0] lp = {$urandom_range(0, 3), 6'b0} | 32'($urandom_range(0, 3)) | (32'($urandom_range(0, 1)) << 12);
      logic [31:0] rp = {$urandom_range(0, 3), 6'b0} | (32'($urandom_range(0, 1)) << 20);
      step(lp, 1'($urandom_range(0, 1)), rp, 1'($urandom_range(0, 1)), "R6");
    end

    // R1: reset again clears everything.
    rstN = 1'b0;
    resolveValid = 1'b0;
    @(posedge clk);
    #1;
    rstN = 1'b1;
    mdlReset();
    for (int k = 0; k < 4; k++) step(32'(k * 64), 1'b0, '0, 1'b0, "R1");

    resolveValid = 1'b0;
    @(negedge clk);
    #1;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule